// File: doc/BRIEF.md
# Drawing Command Packet Parser

This block sits at the command input of a drawing engine. It takes a stream of 32-bit command words and groups them into whole packets. The top byte of a packet's first word is its opcode, and the opcode fixes how many more words belong to the packet. The block holds each packet in a small buffer until the last word has arrived. It then replays the packet on a valid/ready output, one word per beat, with first and last markers.

While words pass through, the block keeps a shadow copy of eight environment registers. Environment-setting opcodes write these registers, and textured primitives update the texture-page field of register 1. Two of the registers feed the low bits of a status word.

Image transfer opcodes are not replayed. Their position and size words go to a separate transfer engine through a start pulse. While that engine reports that it is busy, input words bypass the parser and go straight to the engine.

Top module: `cmd_packet_parser`

## Requirements
- R1: After reset, `status_low` is 0, `pkt_valid`, `xfer_start` and `dirty_pulse` are low, and `in_ready` is high. Environment register i resets to the value `(0xE0+i)<<24`.
- R2: A packet has 1 + N words, where N comes from the opcode (bits 31:24 of the first word):
  - 0x02 gives 2.
  - 0x20-0x23 give 3, 0x24-0x27 give 6, 0x28-0x2B give 4, 0x2C-0x2F give 8.
  - 0x30-0x33 give 5, 0x34-0x37 give 8, 0x38-0x3B give 7, 0x3C-0x3F give 11.
  - 0x40-0x47 give 2, 0x48-0x57 give 3, 0x58-0x5F give 4, 0x60-0x63 give 2, 0x64-0x67 give 3, 0x68-0x6B give 1, 0x6C-0x6F give 0, 0x70-0x73 give 1, 0x74-0x77 give 2, 0x78-0x7B give 1, 0x7C-0x7F give 2.
  - 0x80 gives 3, and 0xA0 and 0xC0 give 2.
  - Every other opcode gives 0.
- R3: A packet that is not a transfer is replayed on `pkt_data`, in arrival order, only after its last word has been accepted. `pkt_first` marks word 0 and `pkt_last` marks the final word. `in_ready` stays low while the replay is in progress.
- R4: A one-word packet with an opcode of 0xE0-0xE7 stores its whole word into environment register (opcode & 7).
- R5: In a packet whose opcode satisfies `(op & 0xF4) == 0x24`, bits 8:0 of word 4 replace bits 8:0 of environment register 1. When `(op & 0xF4) == 0x34`, word 5 supplies those bits instead.
- R6: In the cycle after the last word of any packet is accepted, `status_low[10:0]` equals environment register 1 bits 10:0 and `status_low[12:11]` equals environment register 6 bits 1:0.
- R7: The packet for opcode 0xA0 (write) or 0xC0 (read) is not replayed. In the cycle after its third word is accepted, `xfer_start` pulses for one cycle. At the same time `xfer_pos` holds word 1, `xfer_size` holds word 2, and `xfer_is_read` is 1 only for 0xC0.
- R8: While `xfer_busy` is high, every input word is accepted and appears on `xfer_wr_data` with `xfer_wr_valid` high in the same cycle. It is not parsed and is not replayed.
- R9: `dirty_pulse` is high for one cycle after the last word of a packet whose opcode lies in 0x02..0xBF. It stays low for all other opcodes.
- R10: While `pkt_valid` is high and `pkt_ready` is low, `pkt_data`, `pkt_first` and `pkt_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word accepted this cycle when valid |
| pkt_valid | output | 1 | Packet word offered |
| pkt_ready | input | 1 | Downstream takes the packet word |
| pkt_data | output | 32 | Packet word |
| pkt_first | output | 1 | First word of packet |
| pkt_last | output | 1 | Final word of packet |
| xfer_busy | input | 1 | Transfer engine is consuming data words |
| xfer_start | output | 1 | One-cycle start of an image transfer |
| xfer_is_read | output | 1 | Transfer direction, 1 means read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_wr_valid | output | 1 | Bypassed data word valid |
| xfer_wr_data | output | 32 | Bypassed data word |
| dirty_pulse | output | 1 | Framebuffer-modifying packet completed |
| status_low | output | 13 | Low status bits taken from the environment shadow |

## Verification
The status bits, the dirty pulse and the transfer start all come from registers loaded at the clock edge that accepts a packet's last word. The bench therefore samples them at the falling edge that follows that acceptance.

Replayed words begin at that same next cycle and advance one per edge where `pkt_ready` is high. A monitor records each word at the falling edge before the edge that takes it. The bypass path has no register, so it is checked at the falling edge of the cycle in which the word is offered.

Each scenario waits a bounded number of cycles for the expected word count, then compares contents, markers and status against a model of environment registers 1 and 6 held in the bench.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ENV_NUM = 8;
  localparam int unsigned STAT_W  = 13;

  typedef enum logic {
    ST_GATHER = 1'b0,
    ST_REPLAY = 1'b1
  } parse_state_e;

  localparam logic [7:0] OP_XFER_WR = 8'hA0;
  localparam logic [7:0] OP_XFER_RD = 8'hC0;
endpackage

// File: rtl/cpp_len_lut.sv
module cpp_len_lut (
  input  logic [7:0] op,
  output logic [3:0] extra
);
  always_comb begin
    extra = 4'd0;
    casez (op)
      8'h02: extra = 4'd2;
      8'b001?_????: begin
        case (op[4:2])
          3'd0: extra = 4'd3;
          3'd1: extra = 4'd6;
          3'd2: extra = 4'd4;
          3'd3: extra = 4'd8;
          3'd4: extra = 4'd5;
          3'd5: extra = 4'd8;
          3'd6: extra = 4'd7;
          default: extra = 4'd11;
        endcase
      end
      8'b01??_????: begin
        case (op[5:2])
          4'h0, 4'h1: extra = 4'd2;
          4'h2, 4'h3, 4'h4, 4'h5: extra = 4'd3;
          4'h6, 4'h7: extra = 4'd4;
          4'h8: extra = 4'd2;
          4'h9: extra = 4'd3;
          4'hA: extra = 4'd1;
          4'hB: extra = 4'd0;
          4'hC: extra = 4'd1;
          4'hD: extra = 4'd2;
          4'hE: extra = 4'd1;
          default: extra = 4'd2;
        endcase
      end
      8'h80: extra = 4'd3;
      8'hA0, 8'hC0: extra = 4'd2;
      default: extra = 4'd0;
    endcase
  end
endmodule

// File: rtl/cpp_env_shadow.sv
module cpp_env_shadow
  import cpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tex_en,
  input  logic [8:0]        tex_bits,
  input  logic              refresh,
  output logic [STAT_W-1:0] status
);
  logic [WORD_W-1:0] env_q [ENV_NUM];
  logic [WORD_W-1:0] env_d [ENV_NUM];
  logic [STAT_W-1:0] status_q, status_d;

  always_comb begin
    for (int i = 0; i < ENV_NUM; i++) env_d[i] = env_q[i];
    if (wr_en) env_d[wr_idx] = wr_data;
    if (tex_en) env_d[1][8:0] = tex_bits;
    status_d = status_q;
    if (refresh) status_d = {env_d[6][1:0], env_d[1][10:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENV_NUM; i++) env_q[i] <= {8'hE0 + 8'(i), 24'h0};
      status_q <= '0;
    end else begin
      for (int i = 0; i < ENV_NUM; i++) env_q[i] <= env_d[i];
      status_q <= status_d;
    end
  end

  assign status = status_q;

  p_tex_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tex_en |=> env_q[1][8:0] == $past(tex_bits));

  p_env_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tex_en) |=> env_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/cmd_packet_parser.sv
module cmd_packet_parser
  import cpp_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        pkt_valid,
  input  logic        pkt_ready,
  output logic [31:0] pkt_data,
  output logic        pkt_first,
  output logic        pkt_last,
  input  logic        xfer_busy,
  output logic        xfer_start,
  output logic        xfer_is_read,
  output logic [31:0] xfer_pos,
  output logic [31:0] xfer_size,
  output logic        xfer_wr_valid,
  output logic [31:0] xfer_wr_data,
  output logic        dirty_pulse,
  output logic [12:0] status_low
);
  localparam int unsigned IDX_W = $clog2(MAX_WORDS);
  localparam int unsigned LEN_W = IDX_W + 1;

  parse_state_e      state_q, state_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d, rd_q, rd_d;
  logic [LEN_W-1:0]  len_q, len_d, len_now;
  logic [7:0]        op_q, op_d, op_now;
  logic [WORD_W-1:0] buf_q [MAX_WORDS];
  logic [3:0]        lut_extra;
  logic              accept, done, is_xfer;
  logic              xs_q, xs_d, xr_q, xr_d, dirty_q, dirty_d;
  logic [WORD_W-1:0] xpos_q, xpos_d, xsize_q, xsize_d;
  logic              env_wr, tex_en;
  logic [8:0]        tex_bits;

  cpp_len_lut u_lut (.op(in_data[31:24]), .extra(lut_extra));

  assign in_ready      = xfer_busy || (state_q == ST_GATHER);
  assign accept        = in_valid && !xfer_busy && (state_q == ST_GATHER);
  assign xfer_wr_valid = in_valid && xfer_busy;
  assign xfer_wr_data  = in_data;

  assign op_now  = (cnt_q == '0) ? in_data[31:24] : op_q;
  assign len_now = (cnt_q == '0) ? ({1'b0, lut_extra} + LEN_W'(1)) : len_q;
  assign done    = accept && (({1'b0, cnt_q} + LEN_W'(1)) == len_now);
  assign is_xfer = (op_now == OP_XFER_WR) || (op_now == OP_XFER_RD);

  assign env_wr   = accept && (cnt_q == '0) && (in_data[31:27] == 5'b11100);
  assign tex_en   = accept && (((cnt_q == IDX_W'(4)) && ((op_q & 8'hF4) == 8'h24)) ||
                               ((cnt_q == IDX_W'(5)) && ((op_q & 8'hF4) == 8'h34)));
  assign tex_bits = in_data[8:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_d    = rd_q;
    len_d   = len_q;
    op_d    = op_q;
    xs_d    = 1'b0;
    xr_d    = xr_q;
    xpos_d  = xpos_q;
    xsize_d = xsize_q;
    dirty_d = 1'b0;
    if (accept) begin
      if (cnt_q == '0) begin
        op_d  = in_data[31:24];
        len_d = len_now;
      end
      cnt_d = cnt_q + IDX_W'(1);
      if (done) begin
        cnt_d   = '0;
        dirty_d = (op_now >= 8'h02) && (op_now < 8'hC0);
        if (is_xfer) begin
          xs_d    = 1'b1;
          xr_d    = (op_now == OP_XFER_RD);
          xpos_d  = buf_q[1];
          xsize_d = in_data;
        end else begin
          state_d = ST_REPLAY;
          rd_d    = '0;
        end
      end
    end
    if (state_q == ST_REPLAY && pkt_ready) begin
      if (({1'b0, rd_q} + LEN_W'(1)) == len_q) state_d = ST_GATHER;
      else rd_d = rd_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GATHER;
      cnt_q   <= '0;
      rd_q    <= '0;
      len_q   <= '0;
      op_q    <= '0;
      xs_q    <= 1'b0;
      xr_q    <= 1'b0;
      xpos_q  <= '0;
      xsize_q <= '0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      len_q   <= len_d;
      op_q    <= op_d;
      xs_q    <= xs_d;
      xr_q    <= xr_d;
      xpos_q  <= xpos_d;
      xsize_q <= xsize_d;
      dirty_q <= dirty_d;
    end
  end

  generate
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q[g] <= '0;
        else if (accept && (cnt_q == IDX_W'(g))) buf_q[g] <= in_data;
      end
    end
  endgenerate

  cpp_env_shadow u_env (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (env_wr),
    .wr_idx  (in_data[26:24]),
    .wr_data (in_data),
    .tex_en  (tex_en),
    .tex_bits(tex_bits),
    .refresh (done),
    .status  (status_low)
  );

  assign pkt_valid    = (state_q == ST_REPLAY);
  assign pkt_data     = buf_q[rd_q];
  assign pkt_first    = pkt_valid && (rd_q == '0);
  assign pkt_last     = pkt_valid && (({1'b0, rd_q} + LEN_W'(1)) == len_q);
  assign xfer_start   = xs_q;
  assign xfer_is_read = xr_q;
  assign xfer_pos     = xpos_q;
  assign xfer_size    = xsize_q;
  assign dirty_pulse  = dirty_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  p_no_intake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !xfer_busy) |-> !in_ready);

  p_xfer_no_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !pkt_valid);

  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !pkt_valid) |=> $stable(cnt_q));

  p_dirty_onecycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_pulse && !$past(accept)) |-> 1'b0);
endmodule

// File: tb/sim_cmd_packet_parser.sv
`timescale 1ns/1ps
module sim_cmd_packet_parser;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, pkt_ready, xfer_busy;
  logic [31:0] in_data;
  logic in_ready, pkt_valid, pkt_first, pkt_last, xfer_start, xfer_is_read;
  logic xfer_wr_valid, dirty_pulse;
  logic [31:0] pkt_data, xfer_pos, xfer_size, xfer_wr_data;
  logic [12:0] status_low;

  int n_chk = 0, n_fail = 0;
  logic [31:0] plog [64];
  logic        pfirst [64];
  logic        plast [64];
  int pcnt = 0, dcnt = 0, xscnt = 0, bcnt = 0;
  logic [31:0] xs_pos, xs_size, blog0;
  logic xs_rd;
  logic [31:0] env1 = 32'hE100_0000, env6 = 32'hE600_0000;
  logic [31:0] words [12];

  always #2.5 clk = ~clk;

  cmd_packet_parser u0 (.*);

  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_valid && pkt_ready && pcnt < 64) begin
        plog[pcnt] = pkt_data; pfirst[pcnt] = pkt_first; plast[pcnt] = pkt_last;
        pcnt++;
      end
      if (dirty_pulse) dcnt++;
      if (xfer_start) begin xscnt++; xs_pos = xfer_pos; xs_size = xfer_size; xs_rd = xfer_is_read; end
      if (xfer_wr_valid) begin if (bcnt == 0) blog0 = xfer_wr_data; bcnt++; end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr;
    pcnt = 0; dcnt = 0; xscnt = 0; bcnt = 0;
  endtask

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_pkts(input int n);
    for (int k = 0; k < 60 && pcnt < n; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [12:0] exp_stat();
    return {env6[1:0], env1[10:0]};
  endfunction

  // sends a packet of n words; w[0] top byte is opcode; checks replay
  task automatic run_pkt(input string req, input int n, input bit dirty);
    clr();
    for (int k = 0; k < n; k++) begin
      if (k == 4 && ((words[0][31:24] & 8'hF4) == 8'h24)) env1[8:0] = words[k][8:0];
      if (k == 5 && ((words[0][31:24] & 8'hF4) == 8'h34)) env1[8:0] = words[k][8:0];
      send(words[k]);
    end
    if (words[0][31:27] == 5'b11100) begin
      if (words[0][26:24] == 3'd1) env1 = words[0];
      if (words[0][26:24] == 3'd6) env6 = words[0];
    end
    wait_pkts(n);
    chk({req, " R2 word count"}, pcnt, n);
    for (int k = 0; k < n && k < pcnt; k++) chk({req, " R3 data"}, plog[k], words[k]);
    if (pcnt > 0) begin
      chk({req, " R3 first"}, pfirst[0], 1);
      chk({req, " R3 last"}, plast[pcnt-1], 1);
    end
    chk({req, " R9 dirty"}, dcnt, dirty ? 1 : 0);
    chk({req, " R6 status"}, status_low, exp_stat());
  endtask

  task automatic t_reset;
    chk("R1 status", status_low, 0);
    chk("R1 pkt_valid", pkt_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 xfer_start", xfer_start, 0);
  endtask

  task automatic t_env;
    words[0] = 32'hE100_0ABC; run_pkt("R4 env1", 1, 0);
    words[0] = 32'hE600_0003; run_pkt("R4 env6", 1, 0);
    words[0] = 32'hE300_1234; run_pkt("R4 env3", 1, 0);
  endtask

  task automatic t_prims;
    for (int k = 0; k < 12; k++) words[k] = 32'h1000_0000 + k * 32'h11;
    words[0] = 32'h2000_0001; run_pkt("R2 op20", 4, 1);
    words[0] = 32'h2400_0002; words[4] = 32'h0000_01F5; run_pkt("R5 op24", 7, 1);
    words[0] = 32'h3400_0003; words[5] = 32'h0000_0066; run_pkt("R5 op34", 9, 1);
    words[0] = 32'h3C00_0004; run_pkt("R2 op3C", 12, 1);
    words[0] = 32'h6800_0005; run_pkt("R2 op68", 2, 1);
    words[0] = 32'h0200_0006; run_pkt("R2 op02", 3, 1);
    words[0] = 32'h0000_0007; run_pkt("R9 op00", 1, 0);
    words[0] = 32'hFF00_0008; run_pkt("R2 opFF", 1, 0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    clr();
    pkt_ready = 1'b0;
    send(32'h2000_0000); send(32'hA); send(32'hB); send(32'hC);
    @(negedge clk);
    held = pkt_data;
    repeat (3) @(negedge clk);
    chk("R10 hold valid", pkt_valid, 1);
    chk("R10 hold data", pkt_data, held);
    chk("R3 no intake", in_ready, 0);
    pkt_ready = 1'b1;
    wait_pkts(4);
    chk("R10 count after release", pcnt, 4);
    chk("R10 last word", plog[3], 32'hC);
  endtask

  task automatic t_xfer(input logic [7:0] op, input bit rd);
    clr();
    send({op, 24'h0}); send(32'h0010_0020); send(32'h0004_0008);
    repeat (3) @(negedge clk);
    chk("R7 start count", xscnt, 1);
    chk("R7 pos", xs_pos, 32'h0010_0020);
    chk("R7 size", xs_size, 32'h0004_0008);
    chk("R7 dir", xs_rd, rd);
    chk("R7 no replay", pcnt, 0);
    chk("R9 xfer dirty", dcnt, rd ? 0 : 1);
    xfer_busy = 1'b1;
    clr();
    send(32'hE100_0555); send(32'h2000_0000);
    xfer_busy = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 bypass count", bcnt, 2);
    chk("R8 bypass data", blog0, 32'hE100_0555);
    chk("R8 not replayed", pcnt, 0);
    chk("R8 env untouched", status_low, exp_stat());
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; pkt_ready = 1'b1; xfer_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_env();
    t_prims();
    t_backpressure();
    t_xfer(8'hA0, 1'b0);
    t_xfer(8'hC0, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule